// File: doc/BRIEF.md
# Dual-Clock PWM Settings Bridge

This block is the register front end of a PWM timer whose counter runs on its own clock, unrelated to the bus clock. Software writes a control word, a period value and a low-phase width through a simple strobe interface with a word address. The block carries those settings, as one consistent set, into the counter clock domain, where they drive the waveform generator. In the other direction it returns the live counter value to the bus, and it turns three one-cycle event strobes from the counter domain into sticky status bits.

The settings are sent again and again without any software request. A sender on the bus clock takes a snapshot of all settings, flips a request toggle and waits for the acknowledge toggle to come back through a two-flop synchronizer. Only then does it take the next snapshot. A receiver on the counter clock loads the snapshot when it sees the request change. The counter readback uses the same mechanism in the other direction. Both directions work whichever clock is faster.

Top module: `pwm_reg_bridge`

## Requirements
- R1: After reset, every register reads zero and all counter-domain setting outputs are zero.
- R2: The word index on `addr` selects the register. Index 0 is control, 1 is period, 2 is low width, 3 is counter readback and 4 is event status. These are byte offsets 0x0, 0x4, 0x8, 0xC and 0x10.
- R3: The control word holds prescale select in bits 17:16, timer mode in bit 2, output inversion in bit 3 and run enable in bit 1. All other control bits read as zero.
- R4: The period and low-width registers each keep a 24-bit value in bits 23:0. Their upper bits read as zero.
- R5: A written setting appears on the counter-domain outputs no later than 6 bus clocks plus 9 counter clocks after the write edge. This holds for a counter clock both slower and faster than the bus clock.
- R6: The counter-domain outputs always show a complete set of settings that existed on the bus side at some moment. They never show a mix of old and new fields.
- R7: Reading index 3 returns the counter value that `cnt_in` presents. A steady counter value is visible within 30 bus clocks plus 12 counter clocks.
- R8: Writes to index 3 change no register, and the readback value is unaffected.
- R9: A one-cycle strobe on `ev_rise`, `ev_fall` or `ev_clr` sets status bit 0, 1 or 2 respectively. The bit is set within 3 counter clocks plus 5 bus clocks and stays set until it is cleared.
- R10: Writing index 4 clears each status bit whose write-data bit is one and leaves the other bits unchanged.
- R11: Reads of indices 5 to 7 return zero, and `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low, asynchronous assert |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the same cycle as `rd_en` |
| pclk | input | 1 | Counter clock |
| prst_n | input | 1 | Counter-domain reset, active low, asynchronous assert |
| cnt_in | input | 24 | Live counter value from the waveform logic |
| ev_rise | input | 1 | Output rising-edge strobe (counter domain) |
| ev_fall | input | 1 | Output falling-edge strobe (counter domain) |
| ev_clr | input | 1 | Counter clear strobe (counter domain) |
| cfg_prescale | output | 2 | Prescale select (counter domain) |
| cfg_invert | output | 1 | Output inversion (counter domain) |
| cfg_tmode | output | 1 | Timer mode (counter domain) |
| cfg_enable | output | 1 | Run enable (counter domain) |
| cfg_cycle | output | 24 | Period value (counter domain) |
| cfg_low | output | 24 | Low-width value (counter domain) |

## Verification
The embedded properties check several rules on every cycle. The sender holds its snapshot while a transfer is open, and the receiver output changes only when a new request arrives. Status bits stay set until a write-one clears them, and such a write really clears them. They also check that readback-register writes leave the settings unchanged, and that reserved control bits and unused addresses read as zero. The latency bound and the coherence of the settings set across two free-running clocks can only be seen in the bench scenarios. These run back-to-back write bursts and compare the counter-domain outputs at every counter edge against the history of bus-side states, first with a slower and then with a faster counter clock.

// File: rtl/pwm_bridge_pkg.sv
`timescale 1ns/1ps
package pwm_bridge_pkg;
  localparam int CNT_W = 24;
  localparam int PS_W  = 2;
  localparam int EV_N  = 3;

  // word indices
  localparam int IDX_CTRL = 0;
  localparam int IDX_CYC  = 1;
  localparam int IDX_LOW  = 2;
  localparam int IDX_CNT  = 3;
  localparam int IDX_STAT = 4;

  // control field positions
  localparam int CTRL_PS_LSB = 16;
  localparam int CTRL_INV    = 3;
  localparam int CTRL_TM     = 2;
  localparam int CTRL_EN     = 1;

  // event bit order in status
  localparam int EV_RISE = 0;
  localparam int EV_FALL = 1;
  localparam int EV_CLR  = 2;

  typedef struct packed {
    logic [PS_W-1:0]  prescale;
    logic             invert;
    logic             tmode;
    logic             enable;
    logic [CNT_W-1:0] cycle;
    logic [CNT_W-1:0] low;
  } pwm_cfg_t;

  localparam int CFG_W = $bits(pwm_cfg_t);
endpackage

// File: rtl/sync_bit.sv
`timescale 1ns/1ps
module sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cdc_snapshot.sv
`timescale 1ns/1ps
module cdc_snapshot #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_data
);
  // source side: snapshot and request toggle
  logic         req_q, req_d, ack_s, idle;
  logic [W-1:0] hold_q, hold_d;
  // destination side
  logic         req_s, seen_q, seen_d, fresh;
  logic [W-1:0] out_q, out_d;

  sync_bit #(.STAGES(STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(seen_q), .q(ack_s));

  assign idle = (req_q == ack_s);

  always_comb begin
    req_d  = req_q;
    hold_d = hold_q;
    if (idle) begin
      req_d  = ~req_q;
      hold_d = src_data;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q <= req_d;
      if (idle) hold_q <= hold_d;
    end
  end

  sync_bit #(.STAGES(STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_q), .q(req_s));

  assign fresh = (req_s != seen_q);

  always_comb begin
    seen_d = req_s;
    out_d  = fresh ? hold_q : out_q;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      seen_q <= 1'b0;
      out_q  <= '0;
    end else begin
      seen_q <= seen_d;
      if (fresh) out_q <= out_d;
    end
  end

  assign dst_data = out_q;

  // R6: snapshot frozen while a transfer is outstanding
  assert_hold_frozen_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (req_q != ack_s) |=> $stable(hold_q));
  // R6: receiver output moves only on a new request
  assert_out_on_request_R6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (req_s == seen_q) |=> $stable(out_q));
endmodule

// File: rtl/evt_cross.sv
`timescale 1ns/1ps
module evt_cross #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         ev_clk,
  input  logic         ev_rst_n,
  input  logic [N-1:0] ev_pulse,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [N-1:0] ev_hit
);
  for (genvar i = 0; i < N; i++) begin : g_ev
    logic tog_q, tog_d, tog_s, prev_q;

    always_comb tog_d = ~tog_q;

    always_ff @(posedge ev_clk or negedge ev_rst_n) begin
      if (!ev_rst_n)        tog_q <= 1'b0;
      else if (ev_pulse[i]) tog_q <= tog_d;
    end

    sync_bit #(.STAGES(STAGES)) u_tog_sync (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(tog_q), .q(tog_s));

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) prev_q <= 1'b0;
      else            prev_q <= tog_s;
    end

    assign ev_hit[i] = tog_s ^ prev_q;
  end
endmodule

// File: rtl/pwm_reg_bridge.sv
`timescale 1ns/1ps
module pwm_reg_bridge
  import pwm_bridge_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bclk,
  input  logic              brst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pclk,
  input  logic              prst_n,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_clr,
  output logic [PS_W-1:0]   cfg_prescale,
  output logic              cfg_invert,
  output logic              cfg_tmode,
  output logic              cfg_enable,
  output logic [CNT_W-1:0]  cfg_cycle,
  output logic [CNT_W-1:0]  cfg_low
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
  localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(IDX_CYC);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(IDX_LOW);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(IDX_CNT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IDX_STAT);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'((1 << PS_W) - 1) << CTRL_PS_LSB) | (DATA_W'(1) << CTRL_INV) |
    (DATA_W'(1) << CTRL_TM) | (DATA_W'(1) << CTRL_EN);

  logic brst_s_n, prst_s_n;

  rst_sync #(.STAGES(SYNC_STAGES)) u_brst (.clk(bclk), .arst_n(brst_n), .rst_n(brst_s_n));
  rst_sync #(.STAGES(SYNC_STAGES)) u_prst (.clk(pclk), .arst_n(prst_n), .rst_n(prst_s_n));

  pwm_cfg_t          cfg_q, cfg_d, cfg_p;
  logic [CFG_W-1:0]  cfg_p_bits;
  logic              wr_ctrl, wr_cyc, wr_low, wr_stat, cfg_en;
  logic [EV_N-1:0]   stat_q, stat_d, ev_hit, clr_vec;
  logic [CNT_W-1:0]  cnt_bus;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CNT_W];

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cyc  = wr_en && (addr == A_CYC);
  assign wr_low  = wr_en && (addr == A_LOW);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign cfg_en  = wr_ctrl || wr_cyc || wr_low;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctrl) begin
      cfg_d.prescale = wdata[CTRL_PS_LSB +: PS_W];
      cfg_d.invert   = wdata[CTRL_INV];
      cfg_d.tmode    = wdata[CTRL_TM];
      cfg_d.enable   = wdata[CTRL_EN];
    end
    if (wr_cyc) cfg_d.cycle = wdata[CNT_W-1:0];
    if (wr_low) cfg_d.low   = wdata[CNT_W-1:0];
  end

  assign clr_vec = wr_stat ? wdata[EV_N-1:0] : '0;

  // a new event wins over a same-cycle clear
  always_comb stat_d = (stat_q & ~clr_vec) | ev_hit;

  always_ff @(posedge bclk or negedge brst_s_n) begin
    if (!brst_s_n) begin
      cfg_q  <= '0;
      stat_q <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      stat_q <= stat_d;
    end
  end

  cdc_snapshot #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_xfer (
    .src_clk(bclk), .src_rst_n(brst_s_n), .src_data(cfg_q),
    .dst_clk(pclk), .dst_rst_n(prst_s_n), .dst_data(cfg_p_bits));

  assign cfg_p = pwm_cfg_t'(cfg_p_bits);

  cdc_snapshot #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_xfer (
    .src_clk(pclk), .src_rst_n(prst_s_n), .src_data(cnt_in),
    .dst_clk(bclk), .dst_rst_n(brst_s_n), .dst_data(cnt_bus));

  evt_cross #(.N(EV_N), .STAGES(SYNC_STAGES)) u_evt (
    .ev_clk(pclk), .ev_rst_n(prst_s_n), .ev_pulse({ev_clr, ev_fall, ev_rise}),
    .dst_clk(bclk), .dst_rst_n(brst_s_n), .ev_hit(ev_hit));

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL: begin
          rdata[CTRL_PS_LSB +: PS_W] = cfg_q.prescale;
          rdata[CTRL_INV]            = cfg_q.invert;
          rdata[CTRL_TM]             = cfg_q.tmode;
          rdata[CTRL_EN]             = cfg_q.enable;
        end
        A_CYC:   rdata[CNT_W-1:0] = cfg_q.cycle;
        A_LOW:   rdata[CNT_W-1:0] = cfg_q.low;
        A_CNT:   rdata[CNT_W-1:0] = cnt_bus;
        A_STAT:  rdata[EV_N-1:0]  = stat_q;
        default: rdata = '0;
      endcase
    end
  end

  assign cfg_prescale = cfg_p.prescale;
  assign cfg_invert   = cfg_p.invert;
  assign cfg_tmode    = cfg_p.tmode;
  assign cfg_enable   = cfg_p.enable;
  assign cfg_cycle    = cfg_p.cycle;
  assign cfg_low      = cfg_p.low;

  assert_cnt_readonly_R8: assert property (@(posedge bclk) disable iff (!brst_s_n)
    (wr_en && addr == A_CNT) |=> $stable(cfg_q));
  assert_sticky_R9: assert property (@(posedge bclk) disable iff (!brst_s_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));
  assert_w1c_R10: assert property (@(posedge bclk) disable iff (!brst_s_n)
    1'b1 |=> ((stat_q & $past(clr_vec & ~ev_hit)) == '0));
  assert_ctrl_reserved_R3: assert property (@(posedge bclk) disable iff (!brst_s_n)
    (rd_en && addr == A_CTRL) |-> ((rdata & ~CTRL_MASK) == '0));
  assert_unused_zero_R11: assert property (@(posedge bclk) disable iff (!brst_s_n)
    (!rd_en || addr > A_STAT) |-> (rdata == '0));
endmodule

// File: tb/pwm_reg_bridge_bench.sv
`timescale 1ns/1ps
module pwm_reg_bridge_bench;
  localparam real TB = 5.0;

  logic        bclk = 1'b0, pclk = 1'b0;
  logic        brst_n, prst_n, wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [23:0] cnt_in;
  logic        ev_rise, ev_fall, ev_clr;
  logic [1:0]  cfg_prescale;
  logic        cfg_invert, cfg_tmode, cfg_enable;
  logic [23:0] cfg_cycle, cfg_low;

  real tp = 7.0;
  real t_wr;
  int  checks = 0, fails = 0;
  bit  mon_on = 0, done = 0;

  // reference model of the bus-visible state
  logic [1:0]  m_ps;
  logic        m_inv, m_tm, m_en;
  logic [23:0] m_cyc, m_low;
  logic [2:0]  m_stat;
  logic [52:0] hist[$];

  always #(TB/2.0) bclk = ~bclk;
  always #(tp/2.0) pclk = ~pclk;

  pwm_reg_bridge u_pwm_reg_bridge (
    .bclk(bclk), .brst_n(brst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pclk(pclk), .prst_n(prst_n), .cnt_in(cnt_in),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_clr(ev_clr),
    .cfg_prescale(cfg_prescale), .cfg_invert(cfg_invert), .cfg_tmode(cfg_tmode),
    .cfg_enable(cfg_enable), .cfg_cycle(cfg_cycle), .cfg_low(cfg_low));

  wire [52:0] dcfg = {cfg_prescale, cfg_invert, cfg_tmode, cfg_enable, cfg_cycle, cfg_low};

  function automatic logic [52:0] mcfg();
    return {m_ps, m_inv, m_tm, m_en, m_cyc, m_low};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge bclk); addr = 3'(a); wdata = d; wr_en = 1'b1;
    @(posedge bclk); t_wr = $realtime;
    case (a)
      0: begin m_ps = d[17:16]; m_inv = d[3]; m_tm = d[2]; m_en = d[1]; end
      1: m_cyc = d[23:0];
      2: m_low = d[23:0];
      4: m_stat = m_stat & ~d[2:0];
      default: ;
    endcase
    hist.push_back(mcfg());
    if (hist.size() > 16) void'(hist.pop_front());
    @(negedge bclk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge bclk); addr = 3'(a); rd_en = 1'b1;
    #1; d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  // sample the outputs just after the latency bound of the last write
  task automatic settle_chk(input string req);
    real rem;
    rem = t_wr + 6.0*TB + 9.0*tp - $realtime;
    if (rem > 0.0) #(rem);
    #0.2;
    chk(req, 64'(dcfg), 64'(mcfg()));
  endtask

  task automatic pulse(input int which);
    @(negedge pclk);
    case (which) 0: ev_rise = 1'b1; 1: ev_fall = 1'b1; default: ev_clr = 1'b1; endcase
    @(negedge pclk);
    ev_rise = 1'b0; ev_fall = 1'b0; ev_clr = 1'b0;
    #(3.0*tp + 5.0*TB + 1.0);
    m_stat[which] = 1'b1;
  endtask

  task automatic cnt_chk(input string req, input logic [23:0] v);
    @(negedge pclk); cnt_in = v;
    repeat (30) @(posedge bclk);
    #(12.0*tp);
    rd_chk(req, 3, {8'h0, v});
  endtask

  // R6: every counter-clock edge, the outputs must match some bus-side state
  always @(negedge pclk) begin
    if (mon_on) begin
      bit ok;
      ok = 1'b0;
      foreach (hist[k]) if (hist[k] === dcfg) ok = 1'b1;
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL R6 actual=%h expected=one of recent bus states, latest %h", dcfg, mcfg());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    brst_n = 0; prst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    cnt_in = '0; ev_rise = 0; ev_fall = 0; ev_clr = 0;
    m_ps = '0; m_inv = 0; m_tm = 0; m_en = 0; m_cyc = '0; m_low = '0; m_stat = '0;
    hist.push_back(53'h0);
    #50;
    brst_n = 1; prst_n = 1;
    repeat (6) @(posedge bclk);
    #(10.0*tp);

    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk("R1", a, 32'h0);
    chk("R1", 64'(dcfg), 64'h0);
    mon_on = 1;

    // R3 control fields and reserved bits, R5 latency
    bus_wr(0, 32'hFFFF_FFFF);
    settle_chk("R5");
    rd_chk("R3", 0, 32'h0003_000E);

    // R4 24-bit fields, R2 mapping
    bus_wr(1, 32'hAB12_3456);
    rd_chk("R4", 1, 32'h0012_3456);
    bus_wr(2, 32'hFF0A_BCDE);
    settle_chk("R5");
    rd_chk("R4", 2, 32'h000A_BCDE);
    bus_wr(0, 32'h0001_0004);
    rd_chk("R2", 0, 32'h0001_0004);
    rd_chk("R2", 1, 32'h0012_3456);
    rd_chk("R2", 2, 32'h000A_BCDE);
    settle_chk("R5");

    // R6 burst of back-to-back writes
    for (int i = 0; i < 6; i++) begin
      bus_wr(1, 32'(24'h100 * (i + 1)));
      bus_wr(2, 32'(24'h011 * (i + 3)));
      bus_wr(0, 32'((i % 4) << 16) | 32'((i & 1) << 3) | 32'h2);
    end
    settle_chk("R6");

    // R7 readback, R8 readback register ignores writes
    cnt_chk("R7", 24'h5A_5A5A);
    bus_wr(3, 32'hFFFF_FFFF);
    rd_chk("R8", 0, {14'h0, m_ps, 12'h0, m_inv, m_tm, m_en, 1'b0});
    rd_chk("R8", 1, {8'h0, m_cyc});
    rd_chk("R8", 2, {8'h0, m_low});
    rd_chk("R8", 3, 32'h005A_5A5A);

    // R9 events
    pulse(0); rd_chk("R9", 4, {29'h0, m_stat});
    pulse(2); rd_chk("R9", 4, {29'h0, m_stat});
    pulse(1); rd_chk("R9", 4, 32'h7);

    // R10 write-one-to-clear
    bus_wr(4, 32'h1); rd_chk("R10", 4, 32'h6);
    bus_wr(4, 32'h0); rd_chk("R10", 4, 32'h6);
    bus_wr(4, 32'h6); rd_chk("R10", 4, 32'h0);

    // R11 unused indices and idle read data
    for (int a = 5; a < 8; a++) rd_chk("R11", a, 32'h0);
    @(negedge bclk); addr = 3'd1; rd_en = 1'b0; #1;
    chk("R11", 64'(rdata), 64'h0);

    // faster counter clock
    tp = 3.0;
    #100;
    bus_wr(1, 32'h00_ABCD);
    bus_wr(0, 32'h0002_000A);
    settle_chk("R5");
    cnt_chk("R7", 24'hC3_0F0F);
    pulse(1); rd_chk("R9", 4, 32'h2);

    // much slower counter clock
    tp = 13.0;
    #200;
    bus_wr(2, 32'h00_0777);
    settle_chk("R5");
    cnt_chk("R7", 24'h00_1234);

    mon_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule